// File: doc/BRIEF.md
# In-band Loopback Code Qualifier

This block watches the recovered receive bit stream of a T1/E1 line, one bit per clock, for the two repeating in-band loopback codes. It reports the arm code and the release code on two status outputs. It also drives an enable that switches remote loopback on and off. A code must first line up with its pattern at some phase. It must then run without interruption for longer than a hold time before its status bit is set.

Elapsed time is measured in pulses of a 1 ms strobe. The hold time is 40 strobes in the normal mode and 5100 strobes when automatic remote loopback is selected. Line errors are tolerated up to an estimated rate of 10^-2. The estimate counts mismatches in consecutive 1000-bit windows. A window that reaches 10 mismatches drops the code being qualified, or clears its status bit if that bit is already set.

The two status bits never stand together. When one code is accepted, any qualification or status of the other code is cleared. Because only the edges of the status bits move the loopback enable, it holds its state in between.

Top module: `ibl_code_qualifier`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `act_det_o`, `deact_det_o` and `rlb_en_o` are 0.
- R2: The arm code is the 5-bit cycle 00001, accepted at any phase. Qualification starts when the last 5 bits equal a rotation of that pattern. With `auto_rlb_i` = 0, `act_det_o` rises on the 41st strobe counted during qualification (strictly more than 40).
- R3: The release code is the 3-bit cycle 001, accepted at any phase. It is qualified the same way and sets `deact_det_o` on the 41st strobe with `auto_rlb_i` = 0.
- R4: With `auto_rlb_i` = 1 the hold is 5100 strobes, so a status bit rises on the 5101st strobe.
- R5: For each code, a mismatch is a received bit that differs from the bit received one code period earlier. Mismatches are counted in consecutive 1000-bit windows. While a window holds fewer than 10 mismatches, an ongoing qualification or a set status bit is kept.
- R6: When the mismatch count of a code reaches 10 within a window, its qualification or status is cleared in that cycle. No new qualification of that code starts until the next window begins.
- R7: `act_det_o` and `deact_det_o` are never 1 together. Acceptance of one code clears qualification and status of the other. If both complete in the same cycle, the arm code wins.
- R8: `rlb_en_o` goes to 1 with a rising edge of `act_det_o` and to 0 with a rising edge of `deact_det_o`. At all other times it keeps its value.
- R9: The qualification timer advances only in cycles where `ms_tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive bit clock, one line bit per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_bit_i | input | 1 | Recovered receive data bit |
| ms_tick_i | input | 1 | One-cycle strobe marking each elapsed millisecond |
| auto_rlb_i | input | 1 | 1 selects automatic remote loopback and the long hold time |
| act_det_o | output | 1 | Arm code qualified |
| deact_det_o | output | 1 | Release code qualified |
| rlb_en_o | output | 1 | Remote loopback enable |

## Verification
Several properties are checked on every cycle. The two status bits are mutually exclusive. The loopback enable follows only the rising edges of the status bits. The timer stays frozen in cycles without a strobe. A status bit can only be entered from qualification on a strobe. The window counter stays in range. The exact cycle of acceptance, the cutoff between 9 and 10 mismatches and the blocking until the window ends can only be shown by the bench scenarios. These depend on the data history, so a cycle-accurate reference model follows the bench stimulus: clean codes, sparse and dense bit errors, code changes, a slowed strobe, the long hold and random noise.

// File: rtl/ibl_pkg.sv
package ibl_pkg;
  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_QUAL = 2'd1,
    TRK_SET  = 2'd2
  } trk_state_e;
endpackage

// File: rtl/ibl_window_ctr.sv
module ibl_window_ctr #(
  parameter int WIN_BITS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic win_end_o
);
  localparam int CNT_W = $clog2(WIN_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_BITS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    win_end_o = (cnt_q == LAST);
    cnt_d     = win_end_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assert_win_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/ibl_code_track.sv
module ibl_code_track
  import ibl_pkg::*;
#(
  parameter int                  PERIOD    = 5,
  parameter logic [PERIOD-1:0]   PATTERN   = 5'b00001,
  parameter int                  ERR_LIMIT = 10,
  parameter int                  TMR_W     = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_bit_i,
  input  logic             ms_tick_i,
  input  logic             win_end_i,
  input  logic             clear_i,
  input  logic [TMR_W-1:0] hold_i,
  output logic             will_set_o,
  output logic             det_o
);
  localparam int ERR_W = $clog2(ERR_LIMIT + 1);
  localparam logic [ERR_W-1:0] LIM = ERR_W'(ERR_LIMIT);
  localparam logic [2*PERIOD-1:0] DBL = {PATTERN, PATTERN};

  trk_state_e        state_q, state_d;
  logic [PERIOD-1:0] hist_q, hist_d;
  logic [ERR_W-1:0]  err_q, err_d, err_now;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [PERIOD-1:0] cur_win;
  logic [PERIOD-1:0] rot_hit;
  logic              aligned, mism, fail;

  assign cur_win = {hist_q[PERIOD-2:0], rx_bit_i};

  genvar g;
  generate
    for (g = 0; g < PERIOD; g++) begin : g_rot
      assign rot_hit[g] = (cur_win == DBL[g +: PERIOD]);
    end
  endgenerate

  always_comb begin
    aligned    = |rot_hit;
    mism       = rx_bit_i ^ hist_q[PERIOD-1];
    err_now    = (err_q >= LIM) ? LIM : err_q + ERR_W'(mism);
    fail       = (err_now >= LIM);
    will_set_o = (state_q == TRK_QUAL) && !fail && ms_tick_i && (tmr_q >= hold_i);
    hist_d     = cur_win;
    err_d      = win_end_i ? '0 : err_now;
    state_d    = state_q;
    tmr_d      = tmr_q;
    unique case (state_q)
      TRK_IDLE: begin
        tmr_d = '0;
        if (!fail && aligned && !clear_i) state_d = TRK_QUAL;
      end
      TRK_QUAL: begin
        if (fail || clear_i)  state_d = TRK_IDLE;
        else if (will_set_o)  state_d = TRK_SET;
        else if (ms_tick_i)   tmr_d   = tmr_q + 1'b1;
      end
      TRK_SET: begin
        if (fail || clear_i)  state_d = TRK_IDLE;
      end
      default: state_d = TRK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TRK_IDLE;
      hist_q  <= '0;
      err_q   <= '0;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      hist_q  <= hist_d;
      err_q   <= err_d;
      tmr_q   <= tmr_d;
    end
  end

  assign det_o = (state_q == TRK_SET);

  assert_set_from_qual_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TRK_SET) && !$past(state_q == TRK_SET)
      |-> $past(state_q == TRK_QUAL) && $past(ms_tick_i));

  assert_tmr_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TRK_QUAL) && $past(state_q == TRK_QUAL) && !$past(ms_tick_i)
      |-> $stable(tmr_q));
endmodule

// File: rtl/ibl_code_qualifier.sv
module ibl_code_qualifier #(
  parameter int WIN_BITS    = 1000,
  parameter int ERR_LIMIT   = 10,
  parameter int HOLD_NORMAL = 40,
  parameter int HOLD_AUTO   = 5100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_bit_i,
  input  logic ms_tick_i,
  input  logic auto_rlb_i,
  output logic act_det_o,
  output logic deact_det_o,
  output logic rlb_en_o
);
  localparam int TMR_W = $clog2(((HOLD_AUTO > HOLD_NORMAL) ? HOLD_AUTO : HOLD_NORMAL) + 1);
  localparam logic [TMR_W-1:0] HOLD_N = TMR_W'(HOLD_NORMAL);
  localparam logic [TMR_W-1:0] HOLD_A = TMR_W'(HOLD_AUTO);

  logic             win_end;
  logic [TMR_W-1:0] hold;
  logic             act_will, deact_will, act_win, deact_win;
  logic             rlb_q, rlb_d;

  assign hold = auto_rlb_i ? HOLD_A : HOLD_N;

  ibl_window_ctr #(.WIN_BITS(WIN_BITS)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .win_end_o (win_end)
  );

  ibl_code_track #(
    .PERIOD(5), .PATTERN(5'b00001), .ERR_LIMIT(ERR_LIMIT), .TMR_W(TMR_W)
  ) u_act (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_bit_i   (rx_bit_i),
    .ms_tick_i  (ms_tick_i),
    .win_end_i  (win_end),
    .clear_i    (deact_win),
    .hold_i     (hold),
    .will_set_o (act_will),
    .det_o      (act_det_o)
  );

  ibl_code_track #(
    .PERIOD(3), .PATTERN(3'b001), .ERR_LIMIT(ERR_LIMIT), .TMR_W(TMR_W)
  ) u_deact (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_bit_i   (rx_bit_i),
    .ms_tick_i  (ms_tick_i),
    .win_end_i  (win_end),
    .clear_i    (act_win),
    .hold_i     (hold),
    .will_set_o (deact_will),
    .det_o      (deact_det_o)
  );

  always_comb begin
    act_win   = act_will;
    deact_win = deact_will && !act_will;
    rlb_d     = rlb_q;
    if (act_win)        rlb_d = 1'b1;
    else if (deact_win) rlb_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rlb_q <= 1'b0;
    else         rlb_q <= rlb_d;
  end

  assign rlb_en_o = rlb_q;

  assert_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act_det_o && deact_det_o));

  assert_rlb_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_det_o) |-> rlb_en_o);

  assert_rlb_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(deact_det_o) |-> !rlb_en_o);

  assert_rlb_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(act_det_o) && !$rose(deact_det_o) |-> $stable(rlb_en_o));
endmodule

// File: tb/ibl_code_qualifier_tb.sv
module ibl_code_qualifier_tb;
  localparam int WIN  = 1000;
  localparam int LIM  = 10;
  localparam int HN   = 40;
  localparam int HA   = 5100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b0;
  logic tick = 1'b0;
  logic auto_rlb = 1'b0;
  logic act_det, deact_det, rlb_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int tick_div = 1;
  int cyc = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  ibl_code_qualifier u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_bit_i(rx_bit), .ms_tick_i(tick),
    .auto_rlb_i(auto_rlb), .act_det_o(act_det), .deact_det_o(deact_det),
    .rlb_en_o(rlb_en)
  );

  // reference model
  int  m_st[2];
  int  m_tmr[2];
  int  m_err[2];
  int  m_bitcnt;
  bit  m_rlb;
  bit  h[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin m_st[k] = 0; m_tmr[k] = 0; m_err[k] = 0; end
      m_bitcnt = 0; m_rlb = 0;
      h = {};
      for (int i = 0; i < 8; i++) h.push_back(1'b0);
    end else begin
      int per[2];
      bit ws[2], fl[2], al[2], clr[2];
      int en[2];
      int hold, ones;
      bit wend, aw, dw;
      per[0] = 5; per[1] = 3;
      hold = auto_rlb ? HA : HN;
      wend = (m_bitcnt == WIN - 1);
      for (int k = 0; k < 2; k++) begin
        ones = rx_bit;
        for (int i = 0; i < per[k] - 1; i++) ones += h[i];
        al[k] = (ones == 1);
        en[k] = m_err[k] + ((rx_bit != h[per[k]-1]) ? 1 : 0);
        if (en[k] > LIM) en[k] = LIM;
        fl[k] = (en[k] >= LIM);
        ws[k] = (m_st[k] == 1) && !fl[k] && tick && (m_tmr[k] >= hold);
      end
      aw = ws[0];
      dw = ws[1] && !ws[0];
      clr[0] = dw; clr[1] = aw;
      for (int k = 0; k < 2; k++) begin
        if (m_st[k] == 0) begin
          m_tmr[k] = 0;
          if (!fl[k] && al[k] && !clr[k]) m_st[k] = 1;
        end else if (m_st[k] == 1) begin
          if (fl[k] || clr[k]) m_st[k] = 0;
          else if (ws[k]) m_st[k] = 2;
          else if (tick) m_tmr[k]++;
        end else begin
          if (fl[k] || clr[k]) m_st[k] = 0;
        end
        m_err[k] = wend ? 0 : en[k];
      end
      if (aw) m_rlb = 1;
      else if (dw) m_rlb = 0;
      h.push_front(rx_bit);
      void'(h.pop_back());
      m_bitcnt = wend ? 0 : m_bitcnt + 1;
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    check(cur_req, "act_det_o", act_det, m_st[0] == 2);
    check(cur_req, "deact_det_o", deact_det, m_st[1] == 2);
    check(cur_req, "rlb_en_o", rlb_en, m_rlb);
  endtask

  task automatic drive(input logic b);
    @(negedge clk);
    if (rst_n) compare_all();
    rx_bit = b;
    tick = ((cyc % tick_div) == 0);
    cyc++;
  endtask

  // per: 5 arm code, 3 release code; flip_every 0 means clean
  task automatic send_code(input int per, input int n, input int flip_every);
    for (int i = 0; i < n; i++) begin
      logic b;
      b = ((i % per) == per - 1);
      if (flip_every > 0 && (i % flip_every) == flip_every - 1) b = ~b;
      drive(b);
    end
  endtask

  task automatic send_noise(input int n);
    for (int i = 0; i < n; i++) drive(1'($urandom));
  endtask

  initial begin
    #(5ns * 60000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1", "act_det_o in reset", act_det, 1'b0);
    check("R1", "deact_det_o in reset", deact_det, 1'b0);
    check("R1", "rlb_en_o in reset", rlb_en, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "act_det_o after release", act_det, 1'b0);
    check("R1", "rlb_en_o after release", rlb_en, 1'b0);

    // R2: clean arm code, normal hold
    cur_req = "R2";
    send_code(5, 44, 0);
    check("R2", "act_det_o not yet after 44 bits", act_det, 1'b0);
    send_code(5, 56, 0);
    check("R2", "act_det_o after clean arm code", act_det, 1'b1);
    check("R8", "rlb_en_o on after arm", rlb_en, 1'b1);

    // R5: sparse errors, fewer than 10 mismatches per window
    cur_req = "R5";
    send_code(5, 2500, 250);
    check("R5", "act_det_o kept under sparse errors", act_det, 1'b1);

    // R6: dense errors clear status
    cur_req = "R6";
    send_code(5, 600, 40);
    check("R6", "act_det_o cleared by dense errors", act_det, 1'b0);
    check("R8", "rlb_en_o holds after status drop", rlb_en, 1'b1);

    // R3/R7: release code
    cur_req = "R3";
    send_code(3, 1100, 0);
    check("R3", "deact_det_o after release code", deact_det, 1'b1);
    check("R7", "act_det_o clear with release", act_det, 1'b0);
    check("R8", "rlb_en_o off after release", rlb_en, 1'b0);

    // R7: arm code takes over from release status
    cur_req = "R7";
    send_code(5, 1200, 0);
    check("R7", "act_det_o after takeover", act_det, 1'b1);
    check("R7", "deact_det_o cleared by takeover", deact_det, 1'b0);

    // R9: slowed strobe
    cur_req = "R9";
    tick_div = 4;
    send_code(3, 1500, 0);
    check("R9", "deact_det_o with slowed strobe", deact_det, 1'b1);
    tick_div = 1;

    // R4: long hold in automatic mode
    cur_req = "R4";
    auto_rlb = 1'b1;
    send_code(5, 3000, 0);
    check("R4", "act_det_o not before long hold", act_det, 1'b0);
    send_code(5, 4000, 0);
    check("R4", "act_det_o after long hold", act_det, 1'b1);
    auto_rlb = 1'b0;

    // R6: random line noise
    cur_req = "R6";
    send_noise(3000);
    check("R6", "act_det_o cleared by noise", act_det, 1'b0);
    check("R6", "deact_det_o stays clear under noise", deact_det, 1'b0);

    drive(1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule